// File: doc/BRIEF.md
# Single-Step Trace and Stack-Fault Exception Controller

This block sits next to a processor's instruction sequencer. It raises two level-3 exceptions. The first is a single-step trace exception, which follows each retired instruction while the status-register trace bit is set. The second is a stack-fault exception, raised when the system stack overflows or underflows.

After each traced instruction, the block holds the sequencer for a fixed number of flush cycles. It then arbitrates the trace request against the pending stack fault and against external interrupt requests. The winner is issued as a one-cycle exception pulse that carries a source code and a vector address. Each issued exception stands for a long-interrupt entry, which means the status register is pushed and the trace bit is cleared by the core. A return strobe stands for the status-register pop.

While a trace or stack-fault handler runs, the interrupt mask is raised to level 3. A stack fault also sets a sticky flag, which only an explicit clear removes.

Top module: `trace_stkerr_ctl`

## Requirements
- R1: A retire strobe taken while the trace bit is 1, outside a fast interrupt and not in the middle of a repeat is a traced retire. It produces exactly one trace exception: `exc_valid_o` is high for one cycle with `exc_src_o`=2 and `exc_vec_o`=0x0004. The pulse is visible in the cycle that follows the end of the flush.
- R2: After a traced retire, `stall_o` is high for exactly three consecutive cycles, starting in the cycle after the retire edge. Retire strobes that arrive while a trace is pending neither extend the stall nor add a trace.
- R3: A retire taken with `rep_busy_i`=1 is never traced. The retire that follows, with `rep_busy_i`=0, closes the repeated unit and is traced.
- R4: A retire taken with `fast_ctx_i`=1 never stalls and never raises a trace.
- R5: The trace bit is sampled at each retire. With the bit at 0 (for example inside a handler), nothing is traced. Setting the bit inside a handler traces the very next retire.
- R6: An interrupt request whose level is above 3 preempts a pending trace. Its vector is 0x0010 + 2×level and its source code is 1. The trace waits until the mask drops back to 3 or lower.
- R7: From the cycle in which a trace or stack-fault exception is issued until `rti_i`, `mask_o` reads 3. During that time, and while a trace is pending, requests of level 3 or lower are rejected. After `rti_i`, `mask_o` follows `sr_mask_i` again.
- R8: A pulse on `stk_ovf_i` or `stk_unf_i` raises a stack-fault exception with `exc_src_o`=3 and `exc_vec_o`=0x0002.
- R9: `stkerr_o` rises after a stack fault and stays high until `stkerr_clr_i` is asserted.
- R10: When a stack fault and a ready trace compete in the same cycle, the stack fault is issued first and the trace is issued in the next cycle.
- R11: Out of reset, `stall_o`, `exc_valid_o` and `stkerr_o` are 0, and `mask_o` equals `sr_mask_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| rep_busy_i | input | 1 | Retire belongs to an unfinished repeat unit |
| sr_trace_i | input | 1 | Status-register trace bit |
| fast_ctx_i | input | 1 | Core is executing a fast interrupt |
| sr_mask_i | input | 3 | Interrupt mask level from the status register |
| rti_i | input | 1 | Return from interrupt (status-register pop) |
| stk_ovf_i | input | 1 | System-stack overflow pulse |
| stk_unf_i | input | 1 | System-stack underflow pulse |
| stkerr_clr_i | input | 1 | Clears the sticky stack-fault flag |
| irq_req_i | input | 1 | External interrupt request |
| irq_lvl_i | input | 3 | Priority level of the request |
| stall_o | output | 1 | Flush stall, forces no-operation issue |
| exc_valid_o | output | 1 | Exception issued this cycle |
| exc_src_o | output | 2 | 1 interrupt, 2 trace, 3 stack fault |
| exc_vec_o | output | 16 | Vector address of the issued exception |
| mask_o | output | 3 | Effective interrupt mask level |
| stkerr_o | output | 1 | Sticky stack-fault flag |

## Verification
Two collisions can land in the same cycle here. The first is a stack fault meeting a trace whose flush has just ended. The bench provokes it by pulsing overflow two cycles after a traced retire, and judges it by the order in which the scoreboard receives the stack-fault vector and then the trace vector. The second is an external request that arrives during the flush. Levels 5 and 3 are driven: the first must preempt the trace, and the second must wait until both the trace and its handler's return have completed.

// File: rtl/trace_stkerr_ctl.sv
module trace_stkerr_ctl #(
  parameter int LVLW      = 3,
  parameter int AW        = 16,
  parameter int FLUSH     = 3,
  parameter int TRACE_LVL = 3,
  parameter logic [AW-1:0] STK_VEC   = AW'(16'h0002),
  parameter logic [AW-1:0] TRACE_VEC = AW'(16'h0004),
  parameter logic [AW-1:0] IRQ_BASE  = AW'(16'h0010)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic            rep_busy_i,
  input  logic            sr_trace_i,
  input  logic            fast_ctx_i,
  input  logic [LVLW-1:0] sr_mask_i,
  input  logic            rti_i,
  input  logic            stk_ovf_i,
  input  logic            stk_unf_i,
  input  logic            stkerr_clr_i,
  input  logic            irq_req_i,
  input  logic [LVLW-1:0] irq_lvl_i,
  output logic            stall_o,
  output logic            exc_valid_o,
  output logic [1:0]      exc_src_o,
  output logic [AW-1:0]   exc_vec_o,
  output logic [LVLW-1:0] mask_o,
  output logic            stkerr_o
);
  localparam int CW = $clog2(FLUSH + 1);
  localparam logic [LVLW-1:0] TLVL = LVLW'(TRACE_LVL);
  localparam logic [1:0] SRC_NONE = 2'd0, SRC_IRQ = 2'd1, SRC_TRC = 2'd2, SRC_STK = 2'd3;

  logic [CW-1:0]   flush_cnt;
  logic            trc_pend, se_pend, in_svc;
  logic [LVLW-1:0] svc_mask;
  logic [1:0]      pick;
  logic [AW-1:0]   pick_vec;

  assign stall_o = (flush_cnt != '0);
  assign mask_o  = in_svc ? svc_mask : sr_mask_i;

  wire trace_hit = retire_i && sr_trace_i && !fast_ctx_i && !rep_busy_i && !trc_pend;
  wire trc_ready = trc_pend && !stall_o && (mask_o <= TLVL);
  wire irq_hi    = irq_req_i && (irq_lvl_i > TLVL) && (irq_lvl_i > mask_o);
  wire irq_ok    = irq_req_i && (irq_lvl_i > mask_o) && !(trc_pend && irq_lvl_i <= TLVL);
  wire stk_evt   = stk_ovf_i || stk_unf_i;

  always_comb begin
    pick     = SRC_NONE;
    pick_vec = '0;
    if (se_pend) begin
      pick = SRC_STK;  pick_vec = STK_VEC;
    end else if (trc_ready && !irq_hi) begin
      pick = SRC_TRC;  pick_vec = TRACE_VEC;
    end else if (irq_ok) begin
      pick = SRC_IRQ;  pick_vec = IRQ_BASE + AW'({irq_lvl_i, 1'b0});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_cnt   <= '0;
      trc_pend    <= 1'b0;
      se_pend     <= 1'b0;
      stkerr_o    <= 1'b0;
      in_svc      <= 1'b0;
      svc_mask    <= '0;
      exc_valid_o <= 1'b0;
      exc_src_o   <= SRC_NONE;
      exc_vec_o   <= '0;
    end else begin
      if (trace_hit) begin
        trc_pend  <= 1'b1;
        flush_cnt <= CW'(FLUSH);
      end else begin
        if (stall_o) flush_cnt <= flush_cnt - 1'b1;
        if (pick == SRC_TRC) trc_pend <= 1'b0;
      end

      if (stk_evt) se_pend <= 1'b1;
      else if (pick == SRC_STK) se_pend <= 1'b0;

      if (stk_evt) stkerr_o <= 1'b1;
      else if (stkerr_clr_i) stkerr_o <= 1'b0;

      exc_valid_o <= (pick != SRC_NONE);
      exc_src_o   <= pick;
      exc_vec_o   <= pick_vec;

      if (pick != SRC_NONE) begin
        in_svc   <= 1'b1;
        svc_mask <= (pick == SRC_IRQ) ? irq_lvl_i : TLVL;
      end else if (rti_i) begin
        in_svc <= 1'b0;
      end
    end
  end

  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= stall_o ? run_len + 1'b1 : '0;
  end

  AST_FLUSH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> run_len == (CW+1)'(FLUSH)); // R2
  AST_FAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && fast_ctx_i) |=> !$rose(stall_o)); // R4
  AST_SVC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_o && exc_src_o[1]) |-> mask_o == TLVL); // R7
  AST_STK_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_o && exc_src_o == SRC_STK) |-> exc_vec_o == STK_VEC); // R8
  AST_STK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stkerr_o && !stkerr_clr_i) |=> stkerr_o); // R9
  AST_STK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_ovf_i || stk_unf_i) |=> stkerr_o); // R9
  AST_TRC_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_o && exc_src_o == SRC_TRC) |-> !stall_o); // R1
endmodule

// File: tb/trace_stkerr_ctl_tb.sv
`timescale 1ns/1ps
module trace_stkerr_ctl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, retire_i, rep_busy_i, sr_trace_i, fast_ctx_i, rti_i;
  logic stk_ovf_i, stk_unf_i, stkerr_clr_i, irq_req_i;
  logic [2:0] sr_mask_i, irq_lvl_i, mask_o;
  logic stall_o, exc_valid_o, stkerr_o;
  logic [1:0] exc_src_o;
  logic [15:0] exc_vec_o;

  trace_stkerr_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .rep_busy_i(rep_busy_i),
    .sr_trace_i(sr_trace_i), .fast_ctx_i(fast_ctx_i), .sr_mask_i(sr_mask_i),
    .rti_i(rti_i), .stk_ovf_i(stk_ovf_i), .stk_unf_i(stk_unf_i),
    .stkerr_clr_i(stkerr_clr_i), .irq_req_i(irq_req_i), .irq_lvl_i(irq_lvl_i),
    .stall_o(stall_o), .exc_valid_o(exc_valid_o), .exc_src_o(exc_src_o),
    .exc_vec_o(exc_vec_o), .mask_o(mask_o), .stkerr_o(stkerr_o));

  int n_cmp = 0, n_bad = 0, n_seen = 0;
  logic [17:0] exp_q[$];
  string tag_q[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(string tag, logic [1:0] s, logic [15:0] v);
    exp_q.push_back({s, v});
    tag_q.push_back(tag);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic retire1(bit rep = 1'b0);
    retire_i = 1'b1; rep_busy_i = rep;
    step();
    retire_i = 1'b0; rep_busy_i = 1'b0;
  endtask

  task automatic stall_count(int cycles, output int c);
    c = 0;
    for (int i = 0; i < cycles; i++) begin
      if (stall_o) c++;
      step();
    end
  endtask

  task automatic rti_pulse();
    rti_i = 1'b1; step(); rti_i = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(negedge clk) begin
    if (rst_n && exc_valid_o) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected exception vector", int'(exc_vec_o), -1);
      end else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({exc_src_o, exc_vec_o} == e, t, "exception {src,vec}",
            int'({exc_src_o, exc_vec_o}), int'(e));
      end
    end
  end

  initial begin
    #(5.0 * 50000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int c, base;
    rst_n = 0; retire_i = 0; rep_busy_i = 0; sr_trace_i = 0; fast_ctx_i = 0;
    rti_i = 0; stk_ovf_i = 0; stk_unf_i = 0; stkerr_clr_i = 0; irq_req_i = 0;
    sr_mask_i = 3'd0; irq_lvl_i = 3'd0;
    step(3);
    rst_n = 1;
    step();
    // R11 reset state
    chk(!stall_o, "R11", "stall_o", stall_o, 0);
    chk(!exc_valid_o, "R11", "exc_valid_o", exc_valid_o, 0);
    chk(!stkerr_o, "R11", "stkerr_o", stkerr_o, 0);
    chk(mask_o == sr_mask_i, "R11", "mask_o", mask_o, sr_mask_i);

    // R1 R2 traced retire, extra retire during flush ignored
    sr_trace_i = 1; base = n_seen;
    push_exp("R1", 2'd2, 16'h0004);
    retire1();
    c = 0;
    for (int i = 0; i < 6; i++) begin
      if (stall_o) c++;
      retire_i = (i == 0);
      step();
    end
    retire_i = 0;
    chk(c == 3, "R2", "stall cycles", c, 3);
    chk(n_seen == base + 1, "R1", "trace count", n_seen - base, 1);
    chk(mask_o == 3, "R7", "mask in trace service", mask_o, 3);
    // R5 handler runs untraced, then sets the bit and traces next retire
    sr_trace_i = 0;
    retire1();
    stall_count(3, c);
    chk(c == 0, "R5", "stall with trace bit clear", c, 0);
    sr_trace_i = 1;
    push_exp("R5", 2'd2, 16'h0004);
    retire1();
    stall_count(6, c);
    chk(c == 3, "R5", "stall after bit set in handler", c, 3);
    chk(n_seen == base + 2, "R5", "trace count", n_seen - base, 2);
    sr_trace_i = 0;
    rti_pulse();
    chk(mask_o == 0, "R7", "mask after return", mask_o, 0);

    // R5 trace bit clear: nothing
    base = n_seen;
    retire1();
    stall_count(4, c);
    chk(c == 0 && n_seen == base, "R5", "untraced retire activity", c + n_seen - base, 0);

    // R3 repeat unit
    sr_trace_i = 1;
    retire1(1'b1); retire1(1'b1); retire1(1'b1);
    stall_count(2, c);
    chk(c == 0, "R3", "stall inside repeat", c, 0);
    push_exp("R3", 2'd2, 16'h0004);
    base = n_seen;
    retire1();
    stall_count(6, c);
    chk(c == 3, "R3", "stall after repeat end", c, 3);
    chk(n_seen == base + 1, "R3", "trace count", n_seen - base, 1);
    rti_pulse();

    // R4 fast interrupt context
    fast_ctx_i = 1; base = n_seen;
    retire1();
    stall_count(4, c);
    chk(c == 0 && n_seen == base, "R4", "fast context activity", c + n_seen - base, 0);
    fast_ctx_i = 0;

    // R6 level-5 request preempts pending trace
    base = n_seen;
    push_exp("R6", 2'd1, 16'h001A);
    push_exp("R6", 2'd2, 16'h0004);
    retire1();
    irq_req_i = 1; irq_lvl_i = 3'd5;
    step();
    irq_req_i = 0;
    step(8);
    chk(n_seen == base + 1, "R6", "exceptions before return", n_seen - base, 1);
    chk(mask_o == 5, "R6", "mask in irq service", mask_o, 5);
    rti_pulse();
    step(3);
    chk(n_seen == base + 2, "R6", "trace after return", n_seen - base, 2);
    rti_pulse();

    // R7 level-3 request loses to trace and waits for return
    base = n_seen;
    push_exp("R7", 2'd2, 16'h0004);
    push_exp("R7", 2'd1, 16'h0016);
    retire1();
    irq_req_i = 1; irq_lvl_i = 3'd3;
    step(8);
    chk(n_seen == base + 1, "R7", "level-3 rejected in service", n_seen - base, 1);
    rti_pulse();
    step(2);
    chk(n_seen == base + 2, "R7", "level-3 after return", n_seen - base, 2);
    irq_req_i = 0;
    rti_pulse();
    chk(mask_o == 0, "R7", "mask restored", mask_o, 0);

    // R10 stack fault and ready trace collide
    base = n_seen;
    push_exp("R10", 2'd3, 16'h0002);
    push_exp("R10", 2'd2, 16'h0004);
    retire1();
    step(2);
    stk_ovf_i = 1; step(); stk_ovf_i = 0;
    step(4);
    chk(n_seen == base + 2, "R10", "both issued", n_seen - base, 2);
    chk(stkerr_o, "R9", "sticky after overflow", stkerr_o, 1);
    chk(mask_o == 3, "R7", "mask after stack+trace", mask_o, 3);
    sr_trace_i = 0;
    rti_pulse();
    step(5);
    chk(stkerr_o, "R9", "sticky holds", stkerr_o, 1);
    stkerr_clr_i = 1; step(); stkerr_clr_i = 0;
    chk(!stkerr_o, "R9", "cleared", stkerr_o, 0);

    // R8 underflow alone
    base = n_seen;
    push_exp("R8", 2'd3, 16'h0002);
    stk_unf_i = 1; step(); stk_unf_i = 0;
    step(3);
    chk(n_seen == base + 1, "R8", "stack fault count", n_seen - base, 1);
    chk(stkerr_o, "R9", "sticky after underflow", stkerr_o, 1);
    chk(mask_o == 3, "R7", "mask in stack service", mask_o, 3);
    stkerr_clr_i = 1; step(); stkerr_clr_i = 0;
    rti_pulse();
    step(3);

    chk(exp_q.size() == 0, "R1", "expected exceptions left", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule